// File: doc/BRIEF.md
# Multi-master System Bus Arbiter

This block lets one local processor share a multi-master system bus with other arbiters of the same kind. It reads the three status lines of its processor on the local clock. From them, plus three strap inputs, it decides when the bus must be requested and when giving it up is permitted. On the bus clock it runs the request, priority, occupancy and common-request handshake with the other arbiters. Toward the local bus controller it drives an active-low address enable.

The occupancy line and the common-request line are open-drain on the board. Here each one is a pull-low enable output plus a sampled wired-AND input, so that several instances, or a bench, can form the shared line. Once the arbiter owns the bus it keeps it. It lets go only when its processor halts, or when another arbiter forces it off through the common-request line or by taking priority. Either lock input can veto a release. Status-derived decisions cross into the bus clock domain through synchronisers, and ownership crosses back the same way before it drives the address enable.

Top module: `mm_bus_arbiter`

## Requirements
- R1: Status `cpu_stat` is decoded as follows: 3'b111 is idle, 3'b011 is halt, 3'b100, 3'b101 and 3'b110 are memory cycles, and 3'b000, 3'b001 and 3'b010 are I/O cycles (3'b000, interrupt acknowledge, counts as I/O). In single-bus mode (`iomode_n`=1, `resmode`=0), any memory or I/O status raises the request: `bus_req_n` goes low on the fourth bus clock edge after the status is applied.
- R2: In I/O-bus mode (`iomode_n`=0, `resmode`=0), only memory cycles request the bus. While the arbiter owns the bus, I/O status opens a release window.
- R3: With `resmode`=1 and `iomode_n`=1, the bus is requested for any memory or I/O cycle only while `sys_sel`=1, and `sys_sel`=0 opens a release window. With `resmode`=0, `sys_sel` has no effect.
- R4: With `iomode_n`=0 and `resmode`=1, only memory cycles with `sys_sel`=1 request the bus. I/O status or `sys_sel`=0 opens a release window.
- R5: A requesting arbiter that does not own the bus takes it (`occ_pull_o`=1) on the bus clock edge where `prio_in_n`=0 and the wired line `occ_n_i`=1. While `occ_n_i` is low it keeps waiting.
- R6: Halt status releases the bus (`occ_pull_o` and the request drop together) unless `lock_n`=0. Without halt or a request from another arbiter, the owner keeps the bus through idle status.
- R7: The owner never drives `creq_pull_o`. A non-owner that is requesting drives it. A low `creq_n_i` releases the owner after two consecutive idle status samples when `yield_any`=0, and after the first idle sample when `yield_any`=1. Release window openings from R2 to R4 also apply.
- R8: `prio_in_n`=1, meaning a higher-priority arbiter has taken priority, releases the owner at the first idle sample or at any release window from R2 to R4.
- R9: `lock_n`=0 blocks every release. `creq_lock_n`=0 blocks only releases caused by `creq_n_i`.
- R10: `prio_out_n` is low exactly when `prio_in_n` is low and the arbiter is neither requesting nor owning the bus.
- R11: `init_n`=0 immediately clears ownership and the request, and forces `addr_en_n` high.
- R12: `addr_en_n` goes low on the second local clock edge after ownership begins, and high on the second local clock edge after it ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Local processor clock |
| bclk | input | 1 | Shared bus clock |
| init_n | input | 1 | Asynchronous active-low initialise |
| cpu_stat | input | 3 | Processor bus-cycle status |
| lock_n | input | 1 | Active-low veto of any release |
| creq_lock_n | input | 1 | Active-low veto of common-request releases |
| iomode_n | input | 1 | Strap, low selects the I/O-bus behaviour |
| resmode | input | 1 | Strap, high selects the resident-bus behaviour |
| yield_any | input | 1 | Strap, high releases on common request at the end of a transfer |
| sys_sel | input | 1 | Address-map select, high targets the shared bus |
| prio_in_n | input | 1 | Priority granted to this arbiter (low) |
| occ_n_i | input | 1 | Sampled wired occupancy line |
| creq_n_i | input | 1 | Sampled wired common-request line |
| bus_req_n | output | 1 | Active-low bus request |
| prio_out_n | output | 1 | Priority passed down the chain (low) |
| occ_pull_o | output | 1 | Pull-low enable for the occupancy line |
| creq_pull_o | output | 1 | Pull-low enable for the common-request line |
| addr_en_n | output | 1 | Active-low address enable toward the bus controller |

## Verification
A status or strap change is sampled on the next local edge and passes two synchroniser flops. So the request reacts on the fourth bus edge after the stimulus, and a grant or a release lands one edge after the request or on that same fourth edge. The address enable follows ownership two local edges later. Priority out is combinational from the current priority input. The bench keeps a behavioural model that delays each decision by exactly these counts. It compares every output at the falling clock edge, between the edge that updates the design and the next change of stimulus. Directed checks wait well past these windows before reading a settled result.

// File: rtl/mm_bus_arbiter.sv
module mm_bus_arbiter #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic       clk,
  input  logic       bclk,
  input  logic       init_n,
  input  logic [2:0] cpu_stat,
  input  logic       lock_n,
  input  logic       creq_lock_n,
  input  logic       iomode_n,
  input  logic       resmode,
  input  logic       yield_any,
  input  logic       sys_sel,
  input  logic       prio_in_n,
  input  logic       occ_n_i,
  input  logic       creq_n_i,
  output logic       bus_req_n,
  output logic       prio_out_n,
  output logic       occ_pull_o,
  output logic       creq_pull_o,
  output logic       addr_en_n
);

  localparam int NSIG  = 5;
  localparam int B_WANT = 0;
  localparam int B_HALT = 1;
  localparam int B_HPW  = 2;
  localparam int B_CQW  = 3;
  localparam int B_LOK  = 4;

  logic st_idle, st_halt, st_mem, st_io;
  logic prev_idle, want_c, offbus_c;
  logic [NSIG-1:0] stage_d, stage_q;

  assign st_idle = (cpu_stat == 3'b111);
  assign st_halt = (cpu_stat == 3'b011);
  assign st_mem  = cpu_stat[2] & ~st_idle;
  assign st_io   = ~cpu_stat[2] & ~st_halt;

  always_comb begin
    case ({iomode_n, resmode})
      2'b10:   begin want_c = st_mem | st_io;            offbus_c = 1'b0;               end
      2'b11:   begin want_c = sys_sel & (st_mem | st_io); offbus_c = ~sys_sel;           end
      2'b00:   begin want_c = st_mem;                     offbus_c = st_io;              end
      default: begin want_c = st_mem & sys_sel;           offbus_c = st_io | ~sys_sel;   end
    endcase
  end

  assign stage_d[B_WANT] = want_c;
  assign stage_d[B_HALT] = st_halt;
  assign stage_d[B_HPW]  = st_idle | offbus_c;
  assign stage_d[B_CQW]  = creq_lock_n &
                           ((yield_any ? st_idle : (st_idle & prev_idle)) | offbus_c);
  assign stage_d[B_LOK]  = lock_n;

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      stage_q   <= '0;
      prev_idle <= 1'b0;
    end else begin
      stage_q   <= stage_d;
      prev_idle <= st_idle;
    end
  end

  logic [NSIG-1:0] xs [SYNC_DEPTH];
  logic [NSIG-1:0] wv;

  always_ff @(posedge bclk or negedge init_n) begin
    if (!init_n) begin
      for (int i = 0; i < SYNC_DEPTH; i++) xs[i] <= '0;
    end else begin
      xs[0] <= stage_q;
      for (int i = 1; i < SYNC_DEPTH; i++) xs[i] <= xs[i-1];
    end
  end

  assign wv = xs[SYNC_DEPTH-1];

  logic own_q, req_q, yield, own_d, req_d;

  assign yield = own_q & wv[B_LOK] &
                 (wv[B_HALT] | (wv[B_HPW] & prio_in_n) | (wv[B_CQW] & ~creq_n_i));
  assign own_d = own_q ? ~yield : (req_q & ~prio_in_n & occ_n_i);
  assign req_d = own_q ? ~yield : wv[B_WANT];

  always_ff @(posedge bclk or negedge init_n) begin
    if (!init_n) begin
      own_q <= 1'b0;
      req_q <= 1'b0;
    end else begin
      own_q <= own_d;
      req_q <= req_d;
    end
  end

  assign bus_req_n   = ~req_q;
  assign occ_pull_o  = own_q;
  assign creq_pull_o = req_q & ~own_q;
  assign prio_out_n  = ~(~prio_in_n & ~req_q & ~own_q);

  logic [SYNC_DEPTH-1:0] aen_s;

  always_ff @(posedge clk or negedge init_n) begin
    if (!init_n) aen_s <= '0;
    else         aen_s <= {aen_s[SYNC_DEPTH-2:0], own_q};
  end

  assign addr_en_n = ~aen_s[SYNC_DEPTH-1];

  // R5: a grant only follows a cycle with priority, a free line and a live request
  a_r5_grab_needs_free: assert property (@(posedge bclk) disable iff (!init_n)
    $rose(occ_pull_o) |-> $past(!prio_in_n && occ_n_i && !bus_req_n));

  // R7: the owner stays off the common-request line
  a_r7_owner_silent: assert property (@(posedge bclk) disable iff (!init_n)
    occ_pull_o |-> !creq_pull_o);

  // R9: a held lock keeps ownership
  a_r9_lock_holds: assert property (@(posedge bclk) disable iff (!init_n)
    (occ_pull_o && !wv[B_LOK]) |=> occ_pull_o);

  // R6: halt with no lock gives the bus up
  a_r6_halt_release: assert property (@(posedge bclk) disable iff (!init_n)
    (occ_pull_o && wv[B_LOK] && wv[B_HALT]) |=> !occ_pull_o);

  // R10: priority passes down only from an idle, priority-holding arbiter
  a_r10_pass_only_idle: assert property (@(posedge bclk) disable iff (!init_n)
    !prio_out_n |-> (!occ_pull_o && bus_req_n && !prio_in_n));

endmodule

// File: tb/mm_bus_arbiter_bench.sv
module mm_bus_arbiter_bench;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic init_n = 1'b0;
  logic [2:0] stat = 3'b111;
  logic lock_n = 1'b1, cqlk_n = 1'b1, iom_n = 1'b1, resm = 1'b0, yany = 1'b0, sys = 1'b0;
  logic pin_n = 1'b0, ext_occ = 1'b0, ext_creq = 1'b0;
  logic occ_n, creq_n;
  logic req_n, pout_n, occ_p, creq_p, aen_n;

  assign occ_n  = ~(occ_p | ext_occ);
  assign creq_n = ~(creq_p | ext_creq);

  mm_bus_arbiter u_mm_bus_arbiter (
    .clk(clk), .bclk(clk), .init_n(init_n), .cpu_stat(stat), .lock_n(lock_n),
    .creq_lock_n(cqlk_n), .iomode_n(iom_n), .resmode(resm), .yield_any(yany),
    .sys_sel(sys), .prio_in_n(pin_n), .occ_n_i(occ_n), .creq_n_i(creq_n),
    .bus_req_n(req_n), .prio_out_n(pout_n), .occ_pull_o(occ_p),
    .creq_pull_o(creq_p), .addr_en_n(aen_n));

  int vecs = 0, bad = 0;
  bit done = 0;

  // behavioural reference: decision word {lock_ok, cq_window, hp_window, halt, want}
  function automatic logic [4:0] decide(logic [2:0] s, logic was_idle);
    logic idle, halt, memc, ioc, want, off, cqw;
    idle = (s == 3'b111);
    halt = (s == 3'b011);
    memc = (s >= 3'd4) && !idle;
    ioc  = (s <= 3'd2);
    if (iom_n && !resm) begin want = memc || ioc; off = 0; end
    else if (iom_n && resm) begin want = sys && (memc || ioc); off = !sys; end
    else if (!iom_n && !resm) begin want = memc; off = ioc; end
    else begin want = memc && sys; off = ioc || !sys; end
    if (yany) cqw = idle || off; else cqw = (idle && was_idle) || off;
    cqw = cqw && cqlk_n;
    return {lock_n, cqw, idle || off, halt, want};
  endfunction

  logic [4:0] d0, d1, d2;
  logic m_idle, m_own, m_req, ma1, ma2;

  always @(posedge clk or negedge init_n) begin
    if (!init_n) begin
      d0 <= 0; d1 <= 0; d2 <= 0; m_idle <= 0; m_own <= 0; m_req <= 0; ma1 <= 0; ma2 <= 0;
    end else begin
      logic go;
      go = m_own && d2[4] && (d2[1] || (d2[2] && pin_n) || (d2[3] && !creq_n));
      d0 <= decide(stat, m_idle);
      d1 <= d0;
      d2 <= d1;
      m_idle <= (stat == 3'b111);
      if (m_own) begin m_own <= !go; m_req <= !go; end
      else begin m_own <= m_req && !pin_n && occ_n; m_req <= d2[0]; end
      ma1 <= m_own;
      ma2 <= ma1;
    end
  end

  task automatic chk(string tag, logic act, logic exp);
    vecs++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      chk("R1 request model", req_n, !m_req);
      chk("R5 ownership model", occ_p, m_own);
      chk("R7 common request model", creq_p, m_req && !m_own);
      chk("R10 priority out model", pout_n, !(!pin_n && !m_req && !m_own));
      chk("R12 address enable model", aen_n, !ma2);
    end
  endtask

  task automatic drop_bus();
    stat = 3'b011; step(8); stat = 3'b111; step(4);
  endtask

  initial begin
    step(3);
    chk("R11 reset req", req_n, 1'b1);
    chk("R11 reset occ", occ_p, 1'b0);
    chk("R11 reset aen", aen_n, 1'b1);
    chk("R11 reset creq", creq_p, 1'b0);
    init_n = 1'b1;
    step(2);

    // R1 single-bus request and R5 grant, R12 enable, R6 keep then halt
    stat = 3'b100; step(3);
    chk("R1 no request before sync", req_n, 1'b1);
    step(1);
    chk("R1 request on fourth edge", req_n, 1'b0);
    step(4);
    chk("R5 owned", occ_p, 1'b1);
    chk("R12 enable low", aen_n, 1'b0);
    stat = 3'b111; step(10);
    chk("R6 kept through idle", occ_p, 1'b1);
    stat = 3'b011; step(5);
    chk("R6 halt released", occ_p, 1'b0);
    step(3);
    chk("R12 enable high after release", aen_n, 1'b1);
    stat = 3'b111; step(4);

    // R5 wait on busy line, R7 common request pull
    ext_occ = 1; stat = 3'b001; step(8);
    chk("R5 waits while line busy", occ_p, 1'b0);
    chk("R7 non-owner pulls creq", creq_p, 1'b1);
    ext_occ = 0; step(3);
    chk("R5 grant once free", occ_p, 1'b1);
    chk("R7 owner does not pull creq", creq_p, 1'b0);
    stat = 3'b111; ext_creq = 1; step(8);
    chk("R7 creq releases after quiet idle", occ_p, 1'b0);
    ext_creq = 0; step(2);

    // R7 single idle gaps: ANYRQST low keeps, high releases
    stat = 3'b100; step(8);
    begin
      bit dropped = 0;
      ext_creq = 1;
      for (int i = 0; i < 12; i++) begin stat = (i % 2) ? 3'b100 : 3'b111; step(1); if (!occ_p) dropped = 1; end
      chk("R7 no release on single idle gaps", dropped, 1'b0);
      dropped = 0; yany = 1;
      for (int i = 0; i < 12; i++) begin stat = (i % 2) ? 3'b100 : 3'b111; step(1); if (!occ_p) dropped = 1; end
      chk("R7 release at transfer end with yield_any", dropped, 1'b1);
    end
    ext_creq = 0; yany = 0; stat = 3'b111; step(4);

    // R9 locks
    stat = 3'b100; step(8); stat = 3'b111;
    lock_n = 0; ext_creq = 1; pin_n = 1; step(12);
    chk("R9 lock keeps bus", occ_p, 1'b1);
    lock_n = 1; cqlk_n = 0; pin_n = 0; step(12);
    chk("R9 creq lock keeps bus", occ_p, 1'b1);
    pin_n = 1; step(6);
    chk("R8 lost priority releases", occ_p, 1'b0);
    chk("R10 no pass without priority", pout_n, 1'b1);
    ext_creq = 0; cqlk_n = 1; pin_n = 0; step(2);
    chk("R10 pass when idle with priority", pout_n, 1'b0);

    // R2 I/O-bus mode
    iom_n = 0; stat = 3'b001; step(8);
    chk("R2 I/O cycle no request", req_n, 1'b1);
    stat = 3'b101; step(8);
    chk("R2 memory cycle owns", occ_p, 1'b1);
    chk("R10 no pass while owning", pout_n, 1'b1);
    stat = 3'b010; pin_n = 1; step(6);
    chk("R8 release during I/O window", occ_p, 1'b0);
    pin_n = 0; stat = 3'b111; step(4);

    // R3 resident mode and ignore when strap low
    iom_n = 1; resm = 1; sys = 0; stat = 3'b100; step(8);
    chk("R3 no request with sys_sel low", req_n, 1'b1);
    sys = 1; step(8);
    chk("R3 request with sys_sel high", occ_p, 1'b1);
    sys = 0; ext_creq = 1; step(6);
    chk("R3 sys_sel low opens release", occ_p, 1'b0);
    ext_creq = 0; resm = 0; step(8);
    chk("R3 sys_sel ignored when strap low", occ_p, 1'b1);
    drop_bus();

    // R4 combined mode
    iom_n = 0; resm = 1; sys = 1; stat = 3'b001; step(8);
    chk("R4 I/O cycle no request", req_n, 1'b1);
    stat = 3'b110; step(8);
    chk("R4 memory with sys_sel owns", occ_p, 1'b1);

    // R11 init while owning
    init_n = 0; #1;
    chk("R11 init clears at once", occ_p, 1'b0);
    chk("R11 init clears request", req_n, 1'b1);
    step(2);
    chk("R11 enable high in init", aen_n, 1'b1);
    init_n = 1; stat = 3'b111; step(4);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
      $finish;
    end
  end
endmodule